// File: doc/BRIEF.md
# Orthogonal Operand Address Generator

This block turns the addressing bytes that follow an orthogonal opcode into one effective address, or one immediate location, per operand. A controller loads the operand descriptors (enable, mode, displacement size code, immediate length) and the current program counter, then pulses `start`. The block walks the instruction stream one byte per cycle through an asynchronous byte port. It reads index registers through a 16-entry register-file port and, for the indirect modes, fetches a 64-bit pointer over a ready/valid data port.

The operands are handled one after the other from a single running stream position, so the bytes of the second operand start where the first ends. On completion the block raises `done` for one cycle and updates the per-operand valid flags, the count of bytes consumed and the next program counter. That counter moves past the consumed bytes only if the advance request was set at `start`. Execution of the instruction, memory writes and flag handling belong to other blocks.

Mode codes on `op_mode` (3 bits per operand): 0 direct (absolute or zero page, displacement only), 1 register indirect, 2 scaled (SIB), 3 immediate, 4 indirect, 5 pre-indexed indirect, 6 post-indexed indirect; 7 behaves as 0.

Top module: `ortho_addr_gen`

## Requirements
- R1: Register-using modes (1, 2, 5, 6) take one register byte: bits [3:0] name the first index register and bits [7:4] the second. The register sum adds both. If the two nibbles are equal, the register is read once and counted once.
- R2: Scaled mode (2) fetches a scale byte first, then the register byte. The effective address is (register sum) × (scale + 1) + displacement, truncated to 64 bits.
- R3: The displacement is `code+1` bytes, little-endian. It is sign-extended from bit 7 for code 0, from bit 15 for code 1, from bit 31 for codes 2 and 3, and used as is for codes 4 to 7. With the displacement disabled its value is zero.
- R4: In modes 0 and 1 the effective address is displacement plus register sum.
- R5: In mode 4 the block reads a 64-bit pointer at the displacement, and the pointer is the effective address.
- R6: In mode 5 the pointer is read at displacement plus register sum, and the pointer is the effective address.
- R7: In mode 6 the pointer is read at the displacement, and the effective address is the pointer plus the register sum.
- R8: In mode 3 the effective address is the current stream position, and the stream then moves forward by the operand's immediate length (4-bit field) without fetching bytes.
- R9: Operand 0 is parsed before operand 1 from one running stream position. `bytes_used` is the total consumed. `pc_out` equals `pc_in + bytes_used` when `pc_adv` was high at `start`; otherwise it equals `pc_in`. `pc_out` changes only together with `done`.
- R10: `done` is a single-cycle pulse. At `done`, `ea_valid` has a one for each enabled operand and a zero for each disabled one, and `ea_valid` changes only together with `done`.
- R11: A pointer request keeps `mem_req_valid` high with a stable `mem_req_addr` until `mem_req_ready` is seen. The response is taken on `mem_rsp_valid`.
- R12: After reset, `done`, `ea_valid` and `mem_req_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin parsing (taken when idle) |
| pc_in | input | AW | Stream position of the first addressing byte |
| pc_adv | input | 1 | Move the program counter past consumed bytes |
| op_en | input | NOPS | Operand is a memory/immediate operand |
| op_mode | input | 3*NOPS | Addressing mode per operand |
| op_disp_en | input | NOPS | Operand carries a displacement |
| op_disp_code | input | 3*NOPS | Displacement size code per operand |
| op_imm_len | input | IMMW*NOPS | Immediate length in bytes per operand |
| ib_addr | output | AW | Instruction byte address |
| ib_data | input | 8 | Instruction byte at `ib_addr` (same cycle) |
| rf_idx | output | RIW | Register-file read index |
| rf_data | input | AW | Register value at `rf_idx` (same cycle) |
| mem_req_valid | output | 1 | Pointer read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | AW | Pointer address |
| mem_rsp_valid | input | 1 | Pointer data valid |
| mem_rsp_data | input | AW | Pointer data |
| done | output | 1 | One-cycle completion pulse |
| ea_valid | output | NOPS | Per-operand result valid |
| ea | output | AW*NOPS | Effective addresses, operand 0 in the low word |
| bytes_used | output | AW | Total addressing bytes consumed |
| pc_out | output | AW | Next program counter |

## Verification
Two events meet in one cycle in the indexed indirect modes. The register sum and the displacement are combined in the same cycle that the pointer request goes out, and for post-indexing the register sum must also be held and added on the cycle the response arrives. The bench places a pre-indexed and a post-indexed operand in one instruction, so the second operand's stream parsing depends on the first's pointer round trip. It judges both addresses and both the request addresses seen on the data port. A stalled request, with ready held low for several cycles, checks that the address stays put and that the result does not land before the response.

// File: rtl/oag_pkg.sv
`timescale 1ns/1ps
package oag_pkg;

  typedef enum logic [2:0] {
    MD_DIRECT = 3'd0,
    MD_RIND   = 3'd1,
    MD_SIB    = 3'd2,
    MD_IMM    = 3'd3,
    MD_IND    = 3'd4,
    MD_PRE    = 3'd5,
    MD_POST   = 3'd6
  } oag_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPSEL,
    ST_SCALE,
    ST_REGS,
    ST_DISP,
    ST_RD_A,
    ST_RD_B,
    ST_CALC,
    ST_PREQ,
    ST_PWAIT,
    ST_NEXT,
    ST_FIN
  } oag_state_e;

  function automatic logic uses_regs(input oag_mode_e m);
    return (m == MD_RIND) || (m == MD_SIB) || (m == MD_PRE) || (m == MD_POST);
  endfunction

endpackage

// File: rtl/oag_sext.sv
`timescale 1ns/1ps
// Sign-extends a little-endian displacement by its size code.
module oag_sext #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] raw,
  input  logic [2:0]    code,
  output logic [AW-1:0] ext
);
  always_comb begin
    case (code)
      3'd0:        ext = {{(AW-8){raw[7]}},   raw[7:0]};
      3'd1:        ext = {{(AW-16){raw[15]}}, raw[15:0]};
      3'd2, 3'd3:  ext = {{(AW-32){raw[31]}}, raw[31:0]};
      default:     ext = raw;
    endcase
  end
endmodule

// File: rtl/oag_ea_calc.sv
`timescale 1ns/1ps
// Combines displacement, register sum and scale into an address or pointer location.
module oag_ea_calc
  import oag_pkg::*;
#(
  parameter int AW   = 64,
  parameter int IMMW = 4
) (
  input  oag_mode_e       mode,
  input  logic [AW-1:0]   disp_raw,
  input  logic [2:0]      code,
  input  logic [AW-1:0]   rsum,
  input  logic [7:0]      scale,
  input  logic [AW-1:0]   sptr,
  input  logic [IMMW-1:0] imm_len,
  output logic [AW-1:0]   ea_direct,
  output logic [AW-1:0]   ptr_addr,
  output logic [AW-1:0]   post_add,
  output logic            need_ptr,
  output logic [AW-1:0]   next_sptr
);
  logic [AW-1:0] dx;
  logic [AW-1:0] mulf;
  logic [AW-1:0] scaled;

  oag_sext #(.AW(AW)) u_sext (.raw(disp_raw), .code(code), .ext(dx));

  assign mulf   = {{(AW-9){1'b0}}, ({1'b0, scale} + 9'd1)};
  assign scaled = (mode == MD_SIB) ? rsum * mulf : rsum;

  always_comb begin
    ea_direct = dx + scaled;
    ptr_addr  = dx;
    post_add  = '0;
    need_ptr  = 1'b0;
    next_sptr = sptr;
    case (mode)
      MD_IMM: begin
        ea_direct = sptr;
        next_sptr = sptr + AW'(imm_len);
      end
      MD_IND:  need_ptr = 1'b1;
      MD_PRE: begin
        need_ptr = 1'b1;
        ptr_addr = dx + rsum;
      end
      MD_POST: begin
        need_ptr = 1'b1;
        post_add = rsum;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ortho_addr_gen.sv
`timescale 1ns/1ps
// Sequential operand address generator for orthogonal instructions.
module ortho_addr_gen
  import oag_pkg::*;
#(
  parameter  int AW   = 64,
  parameter  int NOPS = 2,
  parameter  int NREG = 16,
  parameter  int IMMW = 4,
  localparam int RIW  = $clog2(NREG),
  localparam int OIW  = (NOPS > 1) ? $clog2(NOPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [AW-1:0]        pc_in,
  input  logic                 pc_adv,
  input  logic [NOPS-1:0]      op_en,
  input  logic [3*NOPS-1:0]    op_mode,
  input  logic [NOPS-1:0]      op_disp_en,
  input  logic [3*NOPS-1:0]    op_disp_code,
  input  logic [IMMW*NOPS-1:0] op_imm_len,
  output logic [AW-1:0]        ib_addr,
  input  logic [7:0]           ib_data,
  output logic [RIW-1:0]       rf_idx,
  input  logic [AW-1:0]        rf_data,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [AW-1:0]        mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [AW-1:0]        mem_rsp_data,
  output logic                 done,
  output logic [NOPS-1:0]      ea_valid,
  output logic [AW*NOPS-1:0]   ea,
  output logic [AW-1:0]        bytes_used,
  output logic [AW-1:0]        pc_out
);

  oag_state_e      st;
  logic [OIW-1:0]  oi;
  logic [AW-1:0]   sptr, pc_start, disp, rsum, paddr, padd;
  logic [7:0]      scale;
  logic [RIW-1:0]  ra, rb;
  logic [2:0]      dcnt;
  logic            adv_q;
  logic [AW-1:0]   ea_q [NOPS];
  logic [NOPS-1:0] vflag;
  logic            done_q;
  logic [NOPS-1:0] ea_valid_q;
  logic [AW-1:0]   bytes_q, pc_out_q;

  oag_mode_e       cur_mode;
  logic            cur_den;
  logic [2:0]      cur_code;
  logic [IMMW-1:0] cur_imm;

  assign cur_mode = oag_mode_e'(op_mode[3*int'(oi) +: 3]);
  assign cur_den  = op_disp_en[oi];
  assign cur_code = op_disp_code[3*int'(oi) +: 3];
  assign cur_imm  = op_imm_len[IMMW*int'(oi) +: IMMW];

  logic [AW-1:0] c_ea, c_paddr, c_padd, c_next;
  logic          c_ind;

  oag_ea_calc #(.AW(AW), .IMMW(IMMW)) u_calc (
    .mode      (cur_mode),
    .disp_raw  (disp),
    .code      (cur_code),
    .rsum      (rsum),
    .scale     (scale),
    .sptr      (sptr),
    .imm_len   (cur_imm),
    .ea_direct (c_ea),
    .ptr_addr  (c_paddr),
    .post_add  (c_padd),
    .need_ptr  (c_ind),
    .next_sptr (c_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      oi         <= '0;
      sptr       <= '0;
      pc_start   <= '0;
      disp       <= '0;
      rsum       <= '0;
      paddr      <= '0;
      padd       <= '0;
      scale      <= '0;
      ra         <= '0;
      rb         <= '0;
      dcnt       <= '0;
      adv_q      <= 1'b0;
      vflag      <= '0;
      done_q     <= 1'b0;
      ea_valid_q <= '0;
      bytes_q    <= '0;
      pc_out_q   <= '0;
      for (int k = 0; k < NOPS; k++) ea_q[k] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          pc_start <= pc_in;
          sptr     <= pc_in;
          adv_q    <= pc_adv;
          oi       <= '0;
          vflag    <= '0;
          st       <= ST_OPSEL;
        end
        ST_OPSEL: begin
          disp  <= '0;
          rsum  <= '0;
          scale <= '0;
          dcnt  <= '0;
          ra    <= '0;
          rb    <= '0;
          if (!op_en[oi])                 st <= ST_NEXT;
          else if (cur_mode == MD_SIB)    st <= ST_SCALE;
          else if (uses_regs(cur_mode))   st <= ST_REGS;
          else if (cur_mode == MD_IMM)    st <= ST_CALC;
          else if (cur_den)               st <= ST_DISP;
          else                            st <= ST_CALC;
        end
        ST_SCALE: begin
          scale <= ib_data;
          sptr  <= sptr + 1'b1;
          st    <= ST_REGS;
        end
        ST_REGS: begin
          ra   <= ib_data[RIW-1:0];
          rb   <= ib_data[4 +: RIW];
          sptr <= sptr + 1'b1;
          st   <= cur_den ? ST_DISP : ST_RD_A;
        end
        ST_DISP: begin
          disp[8*int'(dcnt) +: 8] <= ib_data;
          dcnt <= dcnt + 3'd1;
          sptr <= sptr + 1'b1;
          if (dcnt == cur_code) st <= uses_regs(cur_mode) ? ST_RD_A : ST_CALC;
        end
        ST_RD_A: begin
          rsum <= rf_data;
          st   <= (rb != ra) ? ST_RD_B : ST_CALC;
        end
        ST_RD_B: begin
          rsum <= rsum + rf_data;
          st   <= ST_CALC;
        end
        ST_CALC: begin
          sptr <= c_next;
          if (c_ind) begin
            paddr <= c_paddr;
            padd  <= c_padd;
            st    <= ST_PREQ;
          end else begin
            ea_q[oi]  <= c_ea;
            vflag[oi] <= 1'b1;
            st        <= ST_NEXT;
          end
        end
        ST_PREQ: if (mem_req_ready) st <= ST_PWAIT;
        ST_PWAIT: if (mem_rsp_valid) begin
          ea_q[oi]  <= mem_rsp_data + padd;
          vflag[oi] <= 1'b1;
          st        <= ST_NEXT;
        end
        ST_NEXT: begin
          if (oi == OIW'(NOPS-1)) st <= ST_FIN;
          else begin
            oi <= oi + 1'b1;
            st <= ST_OPSEL;
          end
        end
        ST_FIN: begin
          done_q     <= 1'b1;
          ea_valid_q <= vflag;
          bytes_q    <= sptr - pc_start;
          pc_out_q   <= adv_q ? sptr : pc_start;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ib_addr       = sptr;
  assign rf_idx        = (st == ST_RD_B) ? rb : ra;
  assign mem_req_valid = (st == ST_PREQ);
  assign mem_req_addr  = paddr;
  assign done          = done_q;
  assign ea_valid      = ea_valid_q;
  assign bytes_used    = bytes_q;
  assign pc_out        = pc_out_q;

  for (genvar g = 0; g < NOPS; g++) begin : g_ea
    assign ea[g*AW +: AW] = ea_q[g];
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(ea_valid) |-> done); // R10
  AST_PC_WITH_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(pc_out) |-> done); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst) (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
  AST_NO_DUP_REG: assert property (@(posedge clk) disable iff (rst) (st == ST_RD_B) |-> (ra != rb)); // R1
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst) done |-> !mem_req_valid); // R11

endmodule

// File: tb/test_ortho_addr_gen.sv
`timescale 1ns/1ps
module test_ortho_addr_gen;
  localparam int AW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          start = 1'b0, pc_adv = 1'b0;
  logic [63:0]   pc_in = '0;
  logic [1:0]    op_en = '0, op_disp_en = '0;
  logic [5:0]    op_mode = '0, op_disp_code = '0;
  logic [7:0]    op_imm_len = '0;
  logic [63:0]   ib_addr, mem_req_addr, bytes_used, pc_out;
  logic [7:0]    ib_data;
  logic [3:0]    rf_idx;
  logic [63:0]   rf_data;
  logic          mem_req_valid, mem_req_ready, done;
  logic          mem_rsp_valid = 1'b0;
  logic [63:0]   mem_rsp_data = '0;
  logic [1:0]    ea_valid;
  logic [127:0]  ea;

  logic [7:0]    ibmem [256];
  int            stall_cfg = 0, stall_cnt = 0, acc_n = 0, hold_n = 0;
  logic [63:0]   acc_addr = '0;
  int            checks = 0, fails = 0;

  function automatic logic [63:0] rv(input int i);
    return (64'(i + 1) << 40) + 64'(i * 17);
  endfunction
  function automatic logic [63:0] fptr(input logic [63:0] a);
    return a ^ 64'h5A5A_0000_1234_0000;
  endfunction

  assign ib_data       = ibmem[ib_addr[7:0]];
  assign rf_data       = rv(int'(rf_idx));
  assign mem_req_ready = (stall_cnt >= stall_cfg);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= fptr(mem_req_addr);
      acc_addr      <= mem_req_addr;
      acc_n         <= acc_n + 1;
      stall_cnt     <= 0;
    end else if (mem_req_valid) begin
      stall_cnt <= stall_cnt + 1;
      hold_n    <= hold_n + 1;
    end
  end

  ortho_addr_gen i_ortho_addr_gen (
    .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .pc_adv(pc_adv),
    .op_en(op_en), .op_mode(op_mode), .op_disp_en(op_disp_en),
    .op_disp_code(op_disp_code), .op_imm_len(op_imm_len),
    .ib_addr(ib_addr), .ib_data(ib_data), .rf_idx(rf_idx), .rf_data(rf_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .ea_valid(ea_valid), .ea(ea),
    .bytes_used(bytes_used), .pc_out(pc_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go(input logic [63:0] pcv, input logic adv);
    int n = 0;
    @(negedge clk);
    pc_in = pcv; pc_adv = adv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", {63'd0, done}, 64'd1);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk("R10 done single pulse", {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R12 done after reset", {63'd0, done}, 64'd0);
    chk("R12 ea_valid after reset", {62'd0, ea_valid}, 64'd0);
    chk("R12 req after reset", {63'd0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_rind();
    ibmem[8'h20] = 8'h52; ibmem[8'h21] = 8'hF0;
    op_en = 2'b01; op_mode = {3'd0, 3'd1}; op_disp_en = 2'b01; op_disp_code = '0;
    go(64'h0000_0000_8000_0020, 1'b1);
    chk("R1 R3 R4 register indirect", ea[63:0], rv(2) + rv(5) + 64'hFFFF_FFFF_FFFF_FFF0);
    chk("R10 disabled operand invalid", {62'd0, ea_valid}, 64'd1);
    chk("R9 bytes", bytes_used, 64'd2);
    chk("R9 pc advanced", pc_out, 64'h0000_0000_8000_0022);
    after_done();
  endtask

  task automatic t_same();
    ibmem[8'h30] = 8'h33;
    op_en = 2'b01; op_mode = {3'd0, 3'd1}; op_disp_en = 2'b00;
    go(64'h0000_0000_8000_0030, 1'b1);
    chk("R1 equal nibbles counted once", ea[63:0], rv(3));
    chk("R9 bytes no disp", bytes_used, 64'd1);
    after_done();
  endtask

  task automatic t_sib();
    ibmem[8'h40] = 8'h02; ibmem[8'h41] = 8'h21; ibmem[8'h42] = 8'h00; ibmem[8'h43] = 8'h80;
    op_en = 2'b01; op_mode = {3'd0, 3'd2}; op_disp_en = 2'b01; op_disp_code = {3'd0, 3'd1};
    go(64'h0000_0000_8000_0040, 1'b1);
    chk("R2 scaled sum", ea[63:0], (rv(1) + rv(2)) * 64'd3 + 64'hFFFF_FFFF_FFFF_8000);
    chk("R2 bytes", bytes_used, 64'd4);
    after_done();
  endtask

  task automatic t_direct();
    ibmem[8'h50] = 8'h78; ibmem[8'h51] = 8'h56; ibmem[8'h52] = 8'h34; ibmem[8'h53] = 8'h92;
    ibmem[8'h54] = 8'h11; ibmem[8'h55] = 8'h22; ibmem[8'h56] = 8'h83;
    op_en = 2'b11; op_mode = {3'd0, 3'd0}; op_disp_en = 2'b11; op_disp_code = {3'd2, 3'd3};
    go(64'h0000_0000_8000_0050, 1'b0);
    chk("R3 code3 sign extend", ea[63:0], 64'hFFFF_FFFF_9234_5678);
    chk("R3 code2 three bytes", ea[127:64], 64'h0000_0000_0083_2211);
    chk("R9 bytes two operands", bytes_used, 64'd7);
    chk("R9 pc held without advance", pc_out, 64'h0000_0000_8000_0050);
    chk("R10 both valid", {62'd0, ea_valid}, 64'd3);
    after_done();
  endtask

  task automatic t_ind();
    logic [63:0] d = 64'h0123_4567_89AB_CDEF;
    int h0 = hold_n;
    for (int i = 0; i < 8; i++) ibmem[8'h60 + i] = d[8*i +: 8];
    stall_cfg = 3;
    op_en = 2'b01; op_mode = {3'd0, 3'd4}; op_disp_en = 2'b01; op_disp_code = {3'd0, 3'd7};
    go(64'h0000_0000_8000_0060, 1'b1);
    chk("R5 pointer address", acc_addr, d);
    chk("R5 pointer result", ea[63:0], fptr(d));
    chk("R11 request held while stalled", 64'(hold_n - h0), 64'd3);
    chk("R9 bytes eight", bytes_used, 64'd8);
    stall_cfg = 0;
    after_done();
  endtask

  task automatic t_prepost();
    int a0 = acc_n;
    ibmem[8'h80] = 8'h74; ibmem[8'h81] = 8'h08;
    ibmem[8'h82] = 8'h0A; ibmem[8'h83] = 8'h00; ibmem[8'h84] = 8'h10;
    op_en = 2'b11; op_mode = {3'd6, 3'd5}; op_disp_en = 2'b11; op_disp_code = {3'd1, 3'd0};
    go(64'h0000_0000_8000_0080, 1'b1);
    chk("R6 pre-indexed", ea[63:0], fptr(64'd8 + rv(4) + rv(7)));
    chk("R7 post-indexed", ea[127:64], fptr(64'h1000) + rv(10) + rv(0));
    chk("R7 last pointer address", acc_addr, 64'h1000);
    chk("R6 two requests", 64'(acc_n - a0), 64'd2);
    chk("R9 pc after both", pc_out, 64'h0000_0000_8000_0085);
    after_done();
  endtask

  task automatic t_imm();
    ibmem[8'h94] = 8'h61;
    op_en = 2'b11; op_mode = {3'd1, 3'd3}; op_disp_en = 2'b00; op_imm_len = {4'd0, 4'd4};
    go(64'h0000_0000_8000_0090, 1'b1);
    chk("R8 immediate location", ea[63:0], 64'h0000_0000_8000_0090);
    chk("R8 next operand after immediate", ea[127:64], rv(1) + rv(6));
    chk("R8 bytes", bytes_used, 64'd5);
    chk("R9 pc", pc_out, 64'h0000_0000_8000_0095);
    after_done();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ibmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rind();
    t_same();
    t_sib();
    t_direct();
    t_ind();
    t_prepost();
    t_imm();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule